// File: doc/BRIEF.md
# Link Start-Up Sequence Controller

This block sequences the layer-1 start-up of a serial radio link through seven states. The states are standby, layer-1 synchronisation, protocol setup, control-and-management setup, vendor-specific setup, operation and passive. Each negotiation step is confirmed by a completion flag. Software writes the flag through a small register port, or, in pin mode, a hardware negotiator drives it directly. The control-and-management step has a failure exit into the passive state. A loss of synchronisation drops the link back to layer-1 synchronisation and clears every completion flag.

A programmable timer restarts each time the machine enters a state. When it reaches the programmed period it raises an expiry flag, which stays high until the next state change. Software reads the state, the expiry flag and the completion flags from one status/control word. It sets the timer period in a second word. Two auto-mode inputs let the block set the protocol and control-and-management flags by itself.

Top module: `link_startup_ctrl`

## Requirements
- R1: After reset the state is standby (code 0), all completion flags are clear, `timerExpired` is low, word 0 reads 0 and word 1 reads the parameter `TIMER_RESET`.
- R2: Word 0 (address 0) holds the completion flags in bits 3:0 (bit 0 rate done, bit 1 protocol done, bit 2 C&M done, bit 3 vendor-specific done). It holds the state code in bits 10:8 (standby 0, L1 sync 1, protocol 2, C&M 3, vendor-specific 4, operation 5, passive 6) and the expiry flag in bit 16. Word 1 holds the timer period. Every other address reads 0.
- R3: Standby moves to L1 sync on the clock after `startReq` is high. L1 sync moves to protocol only when `syncAcq` is high and flag bit 0 is set.
- R4: A flag becomes visible one clock after its write. The move it enables happens on the following clock: protocol to C&M needs bit 1, C&M to vendor-specific needs bit 2, and vendor-specific to operation needs bit 3.
- R5: In the C&M state, `cmFail` moves the machine to passive on the next clock, whatever bit 2 holds. The block does not set bit 2 itself in that cycle.
- R6: `syncLost` in any state from protocol to passive gives L1 sync and clears bits 3:0 on the next clock. In standby and L1 sync it has no effect.
- R7: With `pinMode` high, each flag bit takes the value of its pin input one clock later, and software writes to bits 3:0 are ignored.
- R8: With `pinMode` low, `autoProtEn` high in the protocol state sets bit 1. `autoCmEn` high in the C&M state without `cmFail` sets bit 2.
- R9: Writes to word 0 change only bits 3:0. Bits 31:17, 15:11 and 7:4 always read 0.
- R10: `timerExpired` rises P+1 clocks after the clock edge that entered the current state, where P is the period. It holds while the state does not change and clears on the clock of the next state change.
- R11: Operation and passive are held while `syncLost` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous active-low reset |
| startReq | input | 1 | Start the link from standby |
| syncAcq | input | 1 | Frame synchronisation acquired |
| syncLost | input | 1 | Frame synchronisation lost |
| cmFail | input | 1 | C&M negotiation failed |
| pinMode | input | 1 | Flags follow the pin inputs |
| pinRateDone | input | 1 | Rate negotiation done pin |
| pinProtDone | input | 1 | Protocol negotiation done pin |
| pinCmDone | input | 1 | C&M negotiation done pin |
| pinVsDone | input | 1 | Vendor-specific negotiation done pin |
| autoProtEn | input | 1 | Block sets protocol flag itself |
| autoCmEn | input | 1 | Block sets C&M flag itself |
| regAddr | input | ADDR_W | Register word address |
| regWe | input | 1 | Register write strobe |
| regWdata | input | 32 | Register write data |
| regRdata | output | 32 | Register read data (combinational on address) |
| stateOut | output | 3 | Current state code |
| timerExpired | output | 1 | Start-up timer expiry flag |

## Verification
The bench goes after the exact cycle on which each gated move happens. A design that checks a flag before it is registered would advance one clock early, and a missing gate would skip a state. It drives the C&M failure, loss of sync from several states and in L1 sync, and the handover between pin mode, software writes and auto mode. A wrong priority there would leave a flag set after a loss of sync or accept a write in pin mode. The timer is checked on the exact expiry cycle and across a state change, where an off-by-one count or a flag that does not clear would show at once.

// File: rtl/lsu_pkg.sv
package lsu_pkg;
  localparam int DATA_W = 32;
  localparam int FLAG_N = 4;
  localparam int STATE_W = 3;

  localparam int FLAG_RATE = 0;
  localparam int FLAG_PROT = 1;
  localparam int FLAG_CM = 2;
  localparam int FLAG_VS = 3;

  localparam int STATE_LSB = 8;
  localparam int EXP_BIT = 16;

  typedef enum logic [STATE_W-1:0] {
    ST_STANDBY = 3'd0,
    ST_L1SYNC  = 3'd1,
    ST_PROTO   = 3'd2,
    ST_CM      = 3'd3,
    ST_VSS     = 3'd4,
    ST_OPER    = 3'd5,
    ST_PASSIVE = 3'd6
  } lsuState_e;

  typedef struct packed {
    logic stateChange;
    logic clearFlags;
    logic autoProt;
    logic autoCm;
  } lsuStrobe_t;
endpackage

// File: rtl/lsuSeqCtrl.sv
module lsuSeqCtrl
  import lsu_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              startReq,
  input  logic              syncAcq,
  input  logic              syncLost,
  input  logic              cmFail,
  input  logic              autoProtEn,
  input  logic              autoCmEn,
  input  logic              pinMode,
  input  logic [FLAG_N-1:0] flags,
  output lsuState_e         state,
  output lsuStrobe_t        strobe
);
  lsuState_e nextState;
  logic lossHit;

  // A loss of sync counts only once the link has passed layer-1 synchronisation.
  assign lossHit = syncLost && (state != ST_STANDBY) && (state != ST_L1SYNC);

  always_comb begin
    nextState = state;
    if (lossHit) begin
      nextState = ST_L1SYNC;
    end else begin
      case (state)
        ST_STANDBY: if (startReq) nextState = ST_L1SYNC;
        ST_L1SYNC:  if (syncAcq && flags[FLAG_RATE]) nextState = ST_PROTO;
        ST_PROTO:   if (flags[FLAG_PROT]) nextState = ST_CM;
        ST_CM: begin
          // The failure exit takes priority over a completed flag.
          if (cmFail) nextState = ST_PASSIVE;
          else if (flags[FLAG_CM]) nextState = ST_VSS;
        end
        ST_VSS:     if (flags[FLAG_VS]) nextState = ST_OPER;
        ST_OPER:    nextState = ST_OPER;
        ST_PASSIVE: nextState = ST_PASSIVE;
        default:    nextState = ST_STANDBY;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_STANDBY;
    else       state <= nextState;
  end

  always_comb begin
    strobe.stateChange = (nextState != state);
    strobe.clearFlags  = lossHit;
    strobe.autoProt    = autoProtEn && !pinMode && (state == ST_PROTO);
    strobe.autoCm      = autoCmEn && !pinMode && !cmFail && (state == ST_CM);
  end
endmodule

// File: rtl/lsuRegPath.sv
module lsuRegPath
  import lsu_pkg::*;
#(
  parameter int ADDR_W = 2,
  parameter int TIMER_W = 32,
  parameter logic [TIMER_W-1:0] TIMER_RESET = 64
) (
  input  logic              clk,
  input  logic              rstN,
  input  lsuStrobe_t        strobe,
  input  lsuState_e         state,
  input  logic              pinMode,
  input  logic [FLAG_N-1:0] pinDone,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWe,
  input  logic [DATA_W-1:0] regWdata,
  output logic [FLAG_N-1:0] flags,
  output logic              timerExpired,
  output logic [DATA_W-1:0] regRdata
);
  localparam logic [ADDR_W-1:0] ADDR_CTL = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] ADDR_PER = ADDR_W'(1);

  logic ctlWrite, perWrite;
  logic [FLAG_N-1:0] autoHit;
  logic [TIMER_W-1:0] periodQ, cntQ;

  assign ctlWrite = regWe && (regAddr == ADDR_CTL);
  assign perWrite = regWe && (regAddr == ADDR_PER);

  always_comb begin
    autoHit = '0;
    autoHit[FLAG_PROT] = strobe.autoProt;
    autoHit[FLAG_CM]   = strobe.autoCm;
  end

  // Per-bit flag registers: clear, then pin, then auto, then software write.
  for (genvar i = 0; i < FLAG_N; i++) begin : g_flag
    always_ff @(posedge clk) begin
      if (!rstN)                 flags[i] <= 1'b0;
      else if (strobe.clearFlags) flags[i] <= 1'b0;
      else if (pinMode)          flags[i] <= pinDone[i];
      else if (autoHit[i])       flags[i] <= 1'b1;
      else if (ctlWrite)         flags[i] <= regWdata[i];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)         periodQ <= TIMER_RESET;
    else if (perWrite) periodQ <= regWdata[TIMER_W-1:0];
  end

  // Timer restarts on every state entry and freezes once expired.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      cntQ <= '0;
      timerExpired <= 1'b0;
    end else if (strobe.stateChange) begin
      cntQ <= '0;
      timerExpired <= 1'b0;
    end else if (!timerExpired) begin
      if (cntQ == periodQ) timerExpired <= 1'b1;
      else                 cntQ <= cntQ + 1'b1;
    end
  end

  always_comb begin
    regRdata = '0;
    if (regAddr == ADDR_CTL) begin
      regRdata[FLAG_N-1:0] = flags;
      regRdata[STATE_LSB +: STATE_W] = state;
      regRdata[EXP_BIT] = timerExpired;
    end else if (regAddr == ADDR_PER) begin
      regRdata[TIMER_W-1:0] = periodQ;
    end
  end
endmodule

// File: rtl/link_startup_ctrl.sv
module link_startup_ctrl
  import lsu_pkg::*;
#(
  parameter int ADDR_W = 2,
  parameter int TIMER_W = 32,
  parameter logic [TIMER_W-1:0] TIMER_RESET = 64
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              startReq,
  input  logic              syncAcq,
  input  logic              syncLost,
  input  logic              cmFail,
  input  logic              pinMode,
  input  logic              pinRateDone,
  input  logic              pinProtDone,
  input  logic              pinCmDone,
  input  logic              pinVsDone,
  input  logic              autoProtEn,
  input  logic              autoCmEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWe,
  input  logic [31:0]       regWdata,
  output logic [31:0]       regRdata,
  output logic [2:0]        stateOut,
  output logic              timerExpired
);
  lsuState_e state;
  lsuStrobe_t strobe;
  logic [FLAG_N-1:0] flagBits;
  logic [FLAG_N-1:0] pinDone;

  assign pinDone = {pinVsDone, pinCmDone, pinProtDone, pinRateDone};
  assign stateOut = state;

  lsuSeqCtrl u_ctrl (
    .clk(clk), .rstN(rstN), .startReq(startReq), .syncAcq(syncAcq),
    .syncLost(syncLost), .cmFail(cmFail), .autoProtEn(autoProtEn),
    .autoCmEn(autoCmEn), .pinMode(pinMode), .flags(flagBits),
    .state(state), .strobe(strobe)
  );

  lsuRegPath #(.ADDR_W(ADDR_W), .TIMER_W(TIMER_W), .TIMER_RESET(TIMER_RESET)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .state(state), .pinMode(pinMode),
    .pinDone(pinDone), .regAddr(regAddr), .regWe(regWe), .regWdata(regWdata),
    .flags(flagBits), .timerExpired(timerExpired), .regRdata(regRdata)
  );
endmodule

// File: rtl/lsuChecker.sv
module lsuChecker (
  input logic       clk,
  input logic       rstN,
  input logic [2:0] state,
  input logic [3:0] flags,
  input logic       syncLost,
  input logic       cmFail,
  input logic       timerExpired
);
  // R6
  lossReturn_chk: assert property (@(posedge clk) disable iff (!rstN)
    (syncLost && state >= 3'd2) |=> (state == 3'd1 && flags == 4'd0));
  // R5
  cmFailExit_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == 3'd3 && cmFail && !syncLost) |=> (state == 3'd6));
  // R4
  protGate_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == 3'd2 && !flags[1]) |=> (state != 3'd3));
  // R10
  expiredClear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state != $past(state)) |-> !timerExpired);
  // R11
  operHold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == 3'd5 && !syncLost) |=> (state == 3'd5));
  // R2
  legalState_chk: assert property (@(posedge clk) disable iff (!rstN)
    state != 3'd7);
endmodule

bind link_startup_ctrl lsuChecker u_lsuChk (
  .clk(clk), .rstN(rstN), .state(stateOut), .flags(flagBits),
  .syncLost(syncLost), .cmFail(cmFail), .timerExpired(timerExpired)
);

// File: tb/link_startup_ctrl_bench.sv
`timescale 1ns/1ps
module link_startup_ctrl_bench;
  localparam int TRST = 64;

  logic clk = 0, rstN = 0;
  logic startReq = 0, syncAcq = 0, syncLost = 0, cmFail = 0, pinMode = 0;
  logic pinRateDone = 0, pinProtDone = 0, pinCmDone = 0, pinVsDone = 0;
  logic autoProtEn = 0, autoCmEn = 0;
  logic [1:0] regAddr = 0;
  logic regWe = 0;
  logic [31:0] regWdata = 0;
  logic [31:0] regRdata;
  logic [2:0] stateOut;
  logic timerExpired;

  int checks = 0, errors = 0, cycles = 0;

  always #2 clk = ~clk;

  link_startup_ctrl #(.TIMER_RESET(TRST)) u_link_startup_ctrl (
    .clk(clk), .rstN(rstN), .startReq(startReq), .syncAcq(syncAcq),
    .syncLost(syncLost), .cmFail(cmFail), .pinMode(pinMode),
    .pinRateDone(pinRateDone), .pinProtDone(pinProtDone), .pinCmDone(pinCmDone),
    .pinVsDone(pinVsDone), .autoProtEn(autoProtEn), .autoCmEn(autoCmEn),
    .regAddr(regAddr), .regWe(regWe), .regWdata(regWdata), .regRdata(regRdata),
    .stateOut(stateOut), .timerExpired(timerExpired)
  );

  // Behavioural reference model
  int mState = 0, mCnt = 0;
  logic [3:0] mFlags = 0;
  logic [31:0] mPeriod = TRST;
  logic mExp = 0;

  always @(posedge clk) begin
    int ns;
    logic [3:0] nf;
    bit loss;
    if (!rstN) begin
      mState = 0; mFlags = 0; mPeriod = TRST; mCnt = 0; mExp = 0;
    end else begin
      loss = syncLost && mState >= 2;
      ns = mState;
      if (loss) ns = 1;
      else if (mState == 0 && startReq) ns = 1;
      else if (mState == 1 && syncAcq && mFlags[0]) ns = 2;
      else if (mState == 2 && mFlags[1]) ns = 3;
      else if (mState == 3 && cmFail) ns = 6;
      else if (mState == 3 && mFlags[2]) ns = 4;
      else if (mState == 4 && mFlags[3]) ns = 5;
      if (loss) nf = 0;
      else if (pinMode) nf = {pinVsDone, pinCmDone, pinProtDone, pinRateDone};
      else begin
        nf = (regWe && regAddr == 0) ? regWdata[3:0] : mFlags;
        if (autoProtEn && mState == 2) nf[1] = 1;
        if (autoCmEn && mState == 3 && !cmFail) nf[2] = 1;
      end
      if (ns != mState) begin mCnt = 0; mExp = 0; end
      else if (!mExp) begin
        if (mCnt == int'(mPeriod)) mExp = 1; else mCnt++;
      end
      if (regWe && regAddr == 1) mPeriod = regWdata;
      mFlags = nf;
      mState = ns;
    end
  end

  function automatic logic [31:0] modelRead(logic [1:0] a);
    if (a == 0) return {15'd0, mExp, 5'd0, 3'(mState), 4'd0, mFlags};
    if (a == 1) return mPeriod;
    return 32'd0;
  endfunction

  // Per-cycle comparison, away from the active edge
  always @(posedge clk) begin
    #1;
    if (rstN) begin
      checks++;
      if (stateOut != 3'(mState)) begin
        errors++; $display("FAIL R4 model state actual=%0d expected=%0d", stateOut, mState);
      end
      checks++;
      if (timerExpired != mExp) begin
        errors++; $display("FAIL R10 model expiry actual=%0b expected=%0b", timerExpired, mExp);
      end
      checks++;
      if (regRdata != modelRead(regAddr)) begin
        errors++; $display("FAIL R2 model read actual=%h expected=%h", regRdata, modelRead(regAddr));
      end
    end
  end

  task automatic expect32(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++; $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step(int n = 1);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic rd(logic [1:0] a, output logic [31:0] d);
    regAddr = a; #0.5; d = regRdata;
  endtask

  task automatic regWrite(logic [1:0] a, logic [31:0] d);
    regAddr = a; regWdata = d; regWe = 1;
    step(1);
    regWe = 0; regAddr = 0;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      errors++;
      $display("FAIL watchdog all-requirements actual=hung expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    step(3);
    rstN = 1;
    step(1);
    // R1 reset state
    expect32("R1 state", 32'(stateOut), 0);
    rd(0, d); expect32("R1 word0", d, 0);
    rd(1, d); expect32("R1 period", d, TRST);
    rd(2, d); expect32("R2 unmapped addr", d, 0);
    // R9 reserved bits
    regWrite(0, 32'hFFFF_FFF0);
    rd(0, d); expect32("R9 reserved", d, 0);
    regWrite(1, 32'd3);
    rd(1, d); expect32("R2 period word", d, 3);
    // R3 standby -> L1 sync
    startReq = 1; step(1); startReq = 0;
    expect32("R3 to L1sync", 32'(stateOut), 1);
    syncAcq = 1; step(3);
    expect32("R3 needs rate flag", 32'(stateOut), 1);
    regWrite(0, 32'h1);
    step(1);
    expect32("R3 to protocol", 32'(stateOut), 2);
    // R10 timer, period 3: rises 4 clocks after entry
    step(3); expect32("R10 not yet", 32'(timerExpired), 0);
    step(1); expect32("R10 expired", 32'(timerExpired), 1);
    expect32("R4 protocol held", 32'(stateOut), 2);
    regWrite(0, 32'h3);
    expect32("R10 holds", 32'(timerExpired), 1);
    step(1);
    expect32("R4 to C&M", 32'(stateOut), 3);
    expect32("R10 cleared on change", 32'(timerExpired), 0);
    // R5 C&M failure
    cmFail = 1; step(1); cmFail = 0;
    rd(0, d); expect32("R5 passive, bit2 clear", d, 32'h603);
    step(5);
    expect32("R11 passive held", 32'(stateOut), 6);
    // R6 loss of sync
    syncLost = 1; step(1); syncLost = 0;
    rd(0, d); expect32("R6 back to L1sync, flags clear", d, 32'h100);
    syncLost = 1; step(1); syncLost = 0;
    expect32("R6 no effect in L1sync", 32'(stateOut), 1);
    // R7 pin mode
    pinMode = 1; pinRateDone = 1; step(1);
    rd(0, d); expect32("R7 pin sets bit0", d[3:0], 32'h1);
    regWrite(0, 32'hE);
    rd(0, d); expect32("R7 write ignored", d, 32'h201);
    // R8 auto protocol and C&M
    pinMode = 0; pinRateDone = 0; autoProtEn = 1; step(1);
    rd(0, d); expect32("R8 auto protocol bit", d, 32'h203);
    step(1);
    expect32("R8 to C&M", 32'(stateOut), 3);
    autoCmEn = 1; step(1);
    rd(0, d); expect32("R8 auto C&M bit", d, 32'h307);
    step(1);
    expect32("R4 to vendor", 32'(stateOut), 4);
    autoProtEn = 0; autoCmEn = 0;
    step(2);
    expect32("R4 vendor held", 32'(stateOut), 4);
    regWrite(0, 32'h8);
    step(1);
    expect32("R4 to operation", 32'(stateOut), 5);
    step(6);
    expect32("R11 operation held", 32'(stateOut), 5);
    syncLost = 1; step(1); syncLost = 0;
    rd(0, d); expect32("R6 loss from operation", d, 32'h100);
    step(2);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule